// File: doc/BRIEF.md
# Handshaked Word Memory Endpoint

This block is a small word-addressed storage array that sits behind a register-bus bridge. Reads and writes each have their own request/acknowledge pair. Each pair follows a four-phase protocol: the requester raises a request, the memory raises an acknowledge, the requester drops the request, and the memory drops the acknowledge. Read and write requests are handled separately, so a bridge can issue either kind and wait for the matching acknowledge.

Writes carry a per-bit mask, so a bridge can update part of a word without first reading it back. Any access whose word index lies at or beyond the configured depth still completes its handshake, but it raises an error flag alongside the acknowledge.

Top module: `hsk_mem_endpoint`

## Requirements
- R1: A read request to an in-range word index returns the full stored word on `rd_data`. `rd_ack` goes high one clock after the request is first sampled high. The read has no mask, so the whole word is always returned.
- R2: Once high, an acknowledge stays high for as long as its request stays high. It falls one clock after the request is sampled low. A new request is accepted only after the acknowledge has returned low.
- R3: An error flag is constant for the whole time its acknowledge is high, and it is low whenever its acknowledge is low.
- R4: A write changes only the storage bits whose `wr_mask` bit is 1. Bits whose mask bit is 0 keep their previous value.
- R5: An access with word index greater than or equal to DEPTH completes with both acknowledge and error high. Such a write changes no entry. Such a read returns all zeros.
- R6: If both requests are pending and idle in the same cycle, the write is accepted first and the read waits. The read is accepted one clock later, so it returns the data just written to the same index.
- R7: A synchronous active-low reset clears both acknowledges, both error flags and `rd_data`. The stored words are not cleared.
- R8: Address, data and mask are sampled only in the cycle a request is accepted. Changes to them while the acknowledge is high have no effect, and `rd_data` stays stable during a read acknowledge.
- R9: A write to an in-range index raises `wr_ack` one clock after `wr_req` is first sampled high, with `wr_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Read request, held until `rd_ack` is high |
| rd_addr | input | ADDR_W | Read word index |
| rd_data | output | WIDTH | Read word, valid while `rd_ack` is high |
| rd_ack | output | 1 | Read acknowledge |
| rd_err | output | 1 | Read error (index out of range) |
| wr_req | input | 1 | Write request, held until `wr_ack` is high |
| wr_addr | input | ADDR_W | Write word index |
| wr_data | input | WIDTH | Write word |
| wr_mask | input | WIDTH | Per-bit write enable, 1 = bit is written |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Write error (index out of range) |

## Verification
A handshake state machine stuck in the wrong state shows at the ports within one clock. The symptom is an acknowledge that fails to rise after a request, or one that fails to fall after the request drops. A corrupted storage word or a wrong mask merge shows only later, when that index is read back. For this reason the bench writes to every index and then reads every index back. A wrong range comparison shows in the same cycle that `rd_ack` or `wr_ack` rises, as a wrong error flag. It can also appear later as a low entry that an out-of-range write has overwritten through address aliasing.

// File: rtl/hsk_mem_pkg.sv
// Shared definitions for the handshaked memory endpoint.
// Assumes nothing beyond the two-state handshake encoding below.
package hsk_mem_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_t;
endpackage

// File: rtl/hsk_chan.sv
// One four-phase handshake channel.
// Accepts a request when it is idle and `allow` is high. It then holds
// `ack` (and `err`, latched from `bad`) until the request drops.
// Assumes the requester keeps `req` high until it sees `ack`.
module hsk_chan
    import hsk_mem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic allow,
    input  logic bad,
    output logic take,
    output logic ack,
    output logic err
);
    ch_state_t state;

    // Accept pulse: a new request seen while idle and not blocked.
    assign take = (state == CH_IDLE) && req && allow;
    assign ack  = (state == CH_BUSY);

    // State and error register for the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            err   <= 1'b0;
        end else if (take) begin
            state <= CH_BUSY;
            err   <= bad;
        end else if (state == CH_BUSY && !req) begin
            state <= CH_IDLE;
            err   <= 1'b0;
        end
    end
endmodule

// File: rtl/hsk_store.sv
// Storage array with a masked write port and a registered read port.
// Assumes the caller never enables read and write in the same cycle.
// The read result register holds its value between reads.
module hsk_store #(
    parameter int DEPTH  = 12,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              w_ok,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  wmask,
    input  logic              re,
    input  logic              r_ok,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] rows [DEPTH];
    logic [IDX_W-1:0] widx, ridx;

    assign widx = waddr[IDX_W-1:0];
    assign ridx = raddr[IDX_W-1:0];

    // Masked write: only bits whose mask bit is set take the new data.
    always_ff @(posedge clk) begin
        if (we && w_ok)
            rows[widx] <= (rows[widx] & ~wmask) | (wdata & wmask);
    end

    // Read register: loaded on an accepted read, zero when out of range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= r_ok ? rows[ridx] : '0;
    end
endmodule

// File: rtl/hsk_mem_endpoint.sv
// Top of the handshaked memory endpoint.
// Two independent handshake channels share one storage array.
// A write is given priority over a read that arrives in the same cycle.
// Assumes word-index addressing; byte translation happens upstream.
module hsk_mem_endpoint #(
    parameter int DEPTH  = 12,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_ack,
    output logic              rd_err,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_mask,
    output logic              wr_ack,
    output logic              wr_err
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    logic wr_take, rd_take, wr_inr, rd_inr, rd_allow;

    // Range checks and arbitration: a write about to be accepted blocks the read.
    assign wr_inr   = (wr_addr < LIMIT);
    assign rd_inr   = (rd_addr < LIMIT);
    assign rd_allow = !(wr_req && !wr_ack);

    hsk_chan u_wr (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .allow(1'b1),
        .bad(!wr_inr), .take(wr_take), .ack(wr_ack), .err(wr_err)
    );

    hsk_chan u_rd (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .allow(rd_allow),
        .bad(!rd_inr), .take(rd_take), .ack(rd_ack), .err(rd_err)
    );

    hsk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_take), .w_ok(wr_inr), .waddr(wr_addr), .wdata(wr_data), .wmask(wr_mask),
        .re(rd_take), .r_ok(rd_inr), .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/hsk_mem_endpoint_chk.sv
// Protocol checker for the handshaked memory endpoint, bound to the top.
// It observes ports only.
module hsk_mem_endpoint_chk #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_ack,
    input logic              rd_err,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  wr_mask,
    input logic              wr_ack,
    input logic              wr_err
);
    AST_RD_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_ack && rd_req) |=> rd_ack); // R2
    AST_WR_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_ack && wr_req) |=> wr_ack); // R2
    AST_RD_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (rd_ack && !rd_req) |=> !rd_ack); // R2
    AST_WR_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_ack && !wr_req) |=> !wr_ack); // R2
    AST_RD_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (rd_ack && rd_req) |=> $stable(rd_err)); // R3
    AST_WR_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (wr_ack && wr_req) |=> $stable(wr_err)); // R3
    AST_RD_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) !rd_ack |-> !rd_err); // R3
    AST_WR_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) !wr_ack |-> !wr_err); // R3
    AST_RD_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (rd_ack && rd_req) |=> $stable(rd_data)); // R8
    AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && rd_req && !rd_ack) |=> (wr_ack && !rd_ack)); // R6
    AST_RD_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_ack) |-> $past(rd_req)); // R1
    AST_WR_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_ack) |-> $past(wr_req)); // R9
endmodule

bind hsk_mem_endpoint hsk_mem_endpoint_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hsk_mem_endpoint_test.sv
// Sweep bench: writes and reads every index of a 12-entry, 16-bit memory,
// including out-of-range indices, against an arithmetic reference model.
module hsk_mem_endpoint_test;
    localparam int DEPTH  = 12;
    localparam int WIDTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH + 1) + 1;
    localparam int NADDR  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0, wr_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
    logic [WIDTH-1:0]  wr_data = '0, wr_mask = '0;
    logic [WIDTH-1:0]  rd_data;
    logic              rd_ack, rd_err, wr_ack, wr_err;

    logic [WIDTH-1:0] model [DEPTH];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hsk_mem_endpoint #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .wr_ack(wr_ack), .wr_err(wr_err)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] m);
        logic bad;
        bad = (a >= DEPTH);
        @(negedge clk);
        wr_addr = ADDR_W'(a); wr_data = d; wr_mask = m; wr_req = 1'b1;
        @(negedge clk);
        check("R9 wr_ack rises", 32'(wr_ack), 32'd1);
        check("R5 wr_err", 32'(wr_err), 32'(bad));
        wr_addr = ~ADDR_W'(a); wr_data = ~d; wr_mask = '1;   // R8: ignored while acked
        @(negedge clk);
        check("R2 wr_ack held", 32'(wr_ack), 32'd1);
        check("R3 wr_err held", 32'(wr_err), 32'(bad));
        wr_req = 1'b0;
        @(negedge clk);
        check("R2 wr_ack falls", 32'(wr_ack), 32'd0);
        check("R3 wr_err low", 32'(wr_err), 32'd0);
        if (!bad) model[a] = (model[a] & ~m) | (d & m);
    endtask

    task automatic do_read(input int a);
        logic bad;
        logic [WIDTH-1:0] exp;
        bad = (a >= DEPTH);
        exp = bad ? '0 : model[a];
        @(negedge clk);
        rd_addr = ADDR_W'(a); rd_req = 1'b1;
        @(negedge clk);
        check("R1 rd_ack rises", 32'(rd_ack), 32'd1);
        check("R5 rd_err", 32'(rd_err), 32'(bad));
        check(bad ? "R5 rd_data zero" : "R1 rd_data", 32'(rd_data), 32'(exp));
        rd_addr = ~ADDR_W'(a);
        @(negedge clk);
        check("R8 rd_data stable", 32'(rd_data), 32'(exp));
        check("R2 rd_ack held", 32'(rd_ack), 32'd1);
        rd_req = 1'b0;
        @(negedge clk);
        check("R2 rd_ack falls", 32'(rd_ack), 32'd0);
        check("R3 rd_err low", 32'(rd_err), 32'd0);
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 rd_ack reset", 32'(rd_ack), 32'd0);
        check("R7 wr_ack reset", 32'(wr_ack), 32'd0);
        check("R7 errs reset", 32'({rd_err, wr_err}), 32'd0);
        check("R7 rd_data reset", 32'(rd_data), 32'd0);
        rst_n = 1'b1;

        // R4 with full mask: fill every index, then out-of-range writes.
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = '0;
            do_write(a, 16'hA5C3 ^ WIDTH'(a * 16'h1111), '1);
        end
        for (int a = DEPTH; a < NADDR; a++)
            do_write(a, 16'hFFFF, '1);            // R5: must not alias
        for (int a = 0; a < NADDR; a++)
            do_read(a);

        // R4: partial masks on every index.
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, 16'h0F0F + WIDTH'(a * 7), 16'h00FF << (a % 9));
            do_write(a, 16'h5A5A, WIDTH'(16'h8001 >> (a % 4)));
        end
        for (int a = 0; a < DEPTH; a++)
            do_read(a);

        // R6: simultaneous requests, the write goes first.
        @(negedge clk);
        wr_addr = 5'd3; wr_data = 16'hBEEF; wr_mask = '1; wr_req = 1'b1;
        rd_addr = 5'd3; rd_req = 1'b1;
        @(negedge clk);
        check("R6 wr_ack first", 32'(wr_ack), 32'd1);
        check("R6 rd waits", 32'(rd_ack), 32'd0);
        model[3] = 16'hBEEF;
        wr_req = 1'b0;
        @(negedge clk);
        check("R6 wr_ack falls", 32'(wr_ack), 32'd0);
        check("R6 rd_ack after", 32'(rd_ack), 32'd1);
        check("R6 rd_data new", 32'(rd_data), 32'h0000BEEF);
        rd_req = 1'b0;
        @(negedge clk);
        check("R2 rd_ack falls", 32'(rd_ack), 32'd0);

        // R7: reset during an erroring read; storage survives.
        @(negedge clk);
        rd_addr = 5'd20; rd_req = 1'b1;
        @(negedge clk);
        check("R5 rd_err set", 32'(rd_err), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 rd_ack cleared", 32'(rd_ack), 32'd0);
        check("R7 rd_err cleared", 32'(rd_err), 32'd0);
        rd_req = 1'b0; rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++)
            do_read(a);                            // R7: contents kept

        finish_run();
    end
endmodule